// File: doc/BRIEF.md
# Real-Time Tick Divider Timer

This block is an 8-bit binary divider that advances once per 256 Hz tick. The tick arrives as a strobe one system clock wide, and the whole block runs in the fast system clock domain. Bit n of the count toggles at 256/2^(n+1) Hz. The falling edges of four chosen bits mark the 32 Hz, 8 Hz, 2 Hz and 1 Hz periods. Each of these edges sets a sticky flag. Software masks each flag with an enable bit, and the masked flags are merged onto one interrupt request line.

Software starts and stops the divider through a control write that carries a run bit and a clear bit. A change of run state waits for the next tick after the write. Because of this, a stop lets one more increment through before the count freezes. The run status output reports the real state of the divider, not the last value written. Clearing the count takes effect at once and never produces flag events.

Top module: `rtc_tick_timer`

## Requirements
- R1: After the asynchronous active-low reset, `count_o` is 0, `run_o` is 0, `flags_o` is 0, `ien_o` is 0 and `irq_o` is 0.
- R2: While `run_o` is 1, every cycle with `tick_256_i` high raises `count_o` by one on the next clock edge, and 255 wraps to 0. Without such a tick, `count_o` does not change.
- R3: A control write with `ctl_run_i`=1 changes nothing until the first tick in a later cycle. On that tick `run_o` becomes 1 and the count does not advance. The first increment comes on the tick after that.
- R4: After a control write with `ctl_run_i`=0 while running, `run_o` stays 1 until the next tick. That tick still increments the count once, and `run_o` falls on the same edge.
- R5: While stopped, ticks leave `count_o` unchanged. After a restart, counting resumes from the held value.
- R6: A control write with `ctl_clr_i`=1 sets `count_o` to 0 on the next edge, whether the divider runs or not, and sets no flag. If the same write has `ctl_run_i`=1, counting then proceeds from 0.
- R7: `flags_o[0]`, `[1]`, `[2]` and `[3]` are set by a falling edge of count bit 2, 4, 6 and 7 respectively. Only a running increment can cause such an edge, so the wrap 255 to 0 sets all four flags.
- R8: A flag stays set, whatever its enable bit is, until a cycle with the matching `flag_clr_i` bit at 1. When a set and a clear of the same flag meet in one cycle, the flag ends up set.
- R9: `ien_we_i` loads `ien_wdata_i` into `ien_o`. `irq_o` is 1 exactly when some bit is 1 in both `flags_o` and `ien_o`.
- R10: When a tick meets a control write in the same cycle, a clear in that write wins over the increment. A run change in that write waits for the following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_256_i | input | 1 | 256 Hz tick strobe, one clock wide |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_run_i | input | 1 | Run bit of the control write (1 run, 0 stop) |
| ctl_clr_i | input | 1 | Clear bit of the control write (1 clears the count) |
| ien_we_i | input | 1 | Interrupt enable write strobe |
| ien_wdata_i | input | 4 | New interrupt enable bits |
| flag_clr_i | input | 4 | Write-one-to-clear strobes for the flags |
| run_o | output | 1 | Actual running status |
| count_o | output | 8 | Current divider count |
| ien_o | output | 4 | Interrupt enable bits |
| flags_o | output | 4 | Sticky flags: 32 Hz, 8 Hz, 2 Hz, 1 Hz |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The hardest states to reach are those where software events land on a tick edge. One case is a clear or run write in the same cycle as a tick. Another is a flag clear in the same cycle as the falling edge that sets that flag. A third is the wrap from 255 to 0, which takes hundreds of running ticks. Directed sequences first walk the count to 7 and to 255 and then line up a clear strobe with the tick. A long seeded random phase follows, with dense ticks and sparse writes, so that the coincidences come up many times. Every output is compared with a cycle model each clock.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

  localparam int CNT_W   = 8;
  localparam int NUM_SRC = 4;

  // Tap of interrupt source idx: three even bits ending two below the top,
  // then the top bit. For an 8-bit divider this gives 2, 4, 6, 7.
  function automatic int tap_pos(input int idx, input int width);
    if (idx >= NUM_SRC - 1)
      return width - 1;
    else
      return width - 6 + 2 * idx;
  endfunction

endpackage

// File: rtl/rtt_run_sync.sv
module rtt_run_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic wr_i,
  input  logic run_wdata_i,
  output logic run_o
);

  logic req_q, req_d;
  logic act_q, act_d;

  // requested state follows the writes
  always_comb begin
    req_d = req_q;
    if (wr_i)
      req_d = run_wdata_i;
  end

  // actual state adopts the request held before this cycle, on a tick only
  always_comb begin
    act_d = act_q;
    if (tick_i)
      act_d = req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      req_q <= req_d;
      act_q <= act_d;
    end
  end

  assign run_o = act_q;

endmodule

// File: rtl/rtt_count.sv
module rtt_count #(
  parameter int CNT_W   = rtt_pkg::CNT_W,
  parameter int NUM_SRC = rtt_pkg::NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               run_i,
  input  logic               clear_i,
  output logic [CNT_W-1:0]   count_o,
  output logic [NUM_SRC-1:0] fall_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             step;

  assign step    = tick_i & run_i & ~clear_i;
  assign cnt_inc = cnt_q + ONE;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)
      cnt_d = '0;
    else if (step)
      cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  // falling edge: tap is 1 now and 0 after the increment
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_tap
    localparam int TAP = rtt_pkg::tap_pos(i, CNT_W);
    assign fall_o[i] = step & cnt_q[TAP] & ~cnt_inc[TAP];
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/rtt_irq.sv
module rtt_irq #(
  parameter int NUM_SRC = rtt_pkg::NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               ien_we_i,
  input  logic [NUM_SRC-1:0] ien_wdata_i,
  output logic [NUM_SRC-1:0] flags_o,
  output logic [NUM_SRC-1:0] ien_o,
  output logic               irq_o
);

  logic [NUM_SRC-1:0] flag_q, flag_d;
  logic [NUM_SRC-1:0] ien_q, ien_d;

  // set has priority over clear
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    assign flag_d[i] = evt_i[i] | (flag_q[i] & ~clr_i[i]);
  end

  always_comb begin
    ien_d = ien_q;
    if (ien_we_i)
      ien_d = ien_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      ien_q  <= '0;
    end else begin
      flag_q <= flag_d;
      ien_q  <= ien_d;
    end
  end

  assign flags_o = flag_q;
  assign ien_o   = ien_q;
  assign irq_o   = |(flag_q & ien_q);

endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer #(
  parameter int CNT_W   = rtt_pkg::CNT_W,
  parameter int NUM_SRC = rtt_pkg::NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_256_i,
  input  logic               ctl_we_i,
  input  logic               ctl_run_i,
  input  logic               ctl_clr_i,
  input  logic               ien_we_i,
  input  logic [NUM_SRC-1:0] ien_wdata_i,
  input  logic [NUM_SRC-1:0] flag_clr_i,
  output logic               run_o,
  output logic [CNT_W-1:0]   count_o,
  output logic [NUM_SRC-1:0] ien_o,
  output logic [NUM_SRC-1:0] flags_o,
  output logic               irq_o
);

  logic               run_act;
  logic               clear;
  logic [NUM_SRC-1:0] fall;

  assign clear = ctl_we_i & ctl_clr_i;

  rtt_run_sync u_run (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_256_i),
    .wr_i        (ctl_we_i),
    .run_wdata_i (ctl_run_i),
    .run_o       (run_act)
  );

  rtt_count #(
    .CNT_W   (CNT_W),
    .NUM_SRC (NUM_SRC)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_256_i),
    .run_i   (run_act),
    .clear_i (clear),
    .count_o (count_o),
    .fall_o  (fall)
  );

  rtt_irq #(
    .NUM_SRC (NUM_SRC)
  ) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (fall),
    .clr_i       (flag_clr_i),
    .ien_we_i    (ien_we_i),
    .ien_wdata_i (ien_wdata_i),
    .flags_o     (flags_o),
    .ien_o       (ien_o),
    .irq_o       (irq_o)
  );

  assign run_o = run_act;

endmodule

// File: rtl/rtt_timer_chk.sv
module rtt_timer_chk #(
  parameter int CNT_W   = rtt_pkg::CNT_W,
  parameter int NUM_SRC = rtt_pkg::NUM_SRC
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_256_i,
  input logic               ctl_we_i,
  input logic               ctl_clr_i,
  input logic               ien_we_i,
  input logic [NUM_SRC-1:0] ien_wdata_i,
  input logic [NUM_SRC-1:0] flag_clr_i,
  input logic               run_o,
  input logic [CNT_W-1:0]   count_o,
  input logic [NUM_SRC-1:0] ien_o,
  input logic [NUM_SRC-1:0] flags_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R2
  inc_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_256_i && run_o && !(ctl_we_i && ctl_clr_i)) |=> (count_o == $past(count_o) + ONE));

  // R2
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick_256_i && run_o) && !(ctl_we_i && ctl_clr_i)) |=> $stable(count_o));

  // R3
  run_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_256_i |=> $stable(run_o));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we_i && ctl_clr_i) |=> (count_o == '0));

  // R6
  clear_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we_i && ctl_clr_i) |=> ((flags_o & ~$past(flags_o)) == '0));

  // R7
  stopped_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |=> ((flags_o & ~$past(flags_o)) == '0));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((($past(flags_o) & ~$past(flag_clr_i))) & ~flags_o) == '0));

  // R9
  ien_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ien_we_i |=> (ien_o == $past(ien_wdata_i)));

endmodule

bind rtc_tick_timer rtt_timer_chk #(
  .CNT_W   (CNT_W),
  .NUM_SRC (NUM_SRC)
) u_rtt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_256_i  (tick_256_i),
  .ctl_we_i    (ctl_we_i),
  .ctl_clr_i   (ctl_clr_i),
  .ien_we_i    (ien_we_i),
  .ien_wdata_i (ien_wdata_i),
  .flag_clr_i  (flag_clr_i),
  .run_o       (run_o),
  .count_o     (count_o),
  .ien_o       (ien_o),
  .flags_o     (flags_o)
);

// File: tb/test_rtc_tick_timer.sv
module test_rtc_tick_timer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, we, run, clr, iwe;
  logic [3:0] iwd, fclr;
  logic       run_o, irq_o;
  logic [7:0] count_o;
  logic [3:0] ien_o, flags_o;

  always #10 clk = ~clk;

  rtc_tick_timer i_rtc_tick_timer (
    .clk(clk), .rst_n(rst_n), .tick_256_i(tick), .ctl_we_i(we),
    .ctl_run_i(run), .ctl_clr_i(clr), .ien_we_i(iwe), .ien_wdata_i(iwd),
    .flag_clr_i(fclr), .run_o(run_o), .count_o(count_o), .ien_o(ien_o),
    .flags_o(flags_o), .irq_o(irq_o)
  );

  int n_vec = 0;
  int n_bad = 0;

  // reference model state
  logic [7:0] m_cnt;
  logic       m_req, m_act;
  logic [3:0] m_flg, m_ien;

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_all(string req);
    chk(req, "count", int'(count_o), int'(m_cnt));
    chk(req, "run",   int'(run_o),   int'(m_act));
    chk(req, "flags", int'(flags_o), int'(m_flg));
    chk(req, "ien",   int'(ien_o),   int'(m_ien));
    chk(req, "irq",   int'(irq_o),   int'(|(m_flg & m_ien)));
  endtask

  task automatic model_clock();
    logic       c, inc;
    logic [7:0] nc;
    logic [3:0] ev;
    c   = we & clr;
    inc = tick & m_act & ~c;
    nc  = c ? 8'd0 : (inc ? m_cnt + 8'd1 : m_cnt);
    ev  = '0;
    if (inc) begin
      ev[0] = m_cnt[2] & ~nc[2];
      ev[1] = m_cnt[4] & ~nc[4];
      ev[2] = m_cnt[6] & ~nc[6];
      ev[3] = m_cnt[7] & ~nc[7];
    end
    m_flg = (m_flg & ~fclr) | ev;
    if (iwe) m_ien = iwd;
    if (tick) m_act = m_req;
    if (we) m_req = run;
    m_cnt = nc;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(logic t, logic w, logic r, logic c, logic ie,
                      logic [3:0] id, logic [3:0] fc, string req);
    tick = t; we = w; run = r; clr = c; iwe = ie; iwd = id; fclr = fc;
    @(posedge clk);
    model_clock();
    @(negedge clk);
    tick = 0; we = 0; run = 0; clr = 0; iwe = 0; iwd = '0; fclr = '0;
    cmp_all(req);
  endtask

  task automatic tk(string req);
    step(1, 0, 0, 0, 0, 4'h0, 4'h0, req);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0;
    tick = 0; we = 0; run = 0; clr = 0; iwe = 0; iwd = '0; fclr = '0;
    m_cnt = '0; m_req = 0; m_act = 0; m_flg = '0; m_ien = '0;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "count", int'(count_o), 0);
    chk("R1", "run",   int'(run_o), 0);
    chk("R1", "flags", int'(flags_o), 0);
    chk("R1", "ien",   int'(ien_o), 0);
    chk("R1", "irq",   int'(irq_o), 0);
    rst_n = 1;
    @(negedge clk);

    // R3 start waits for a later tick, which itself does not count
    step(0, 1, 1, 0, 0, 4'h0, 4'h0, "R3");
    chk("R3", "run before tick", int'(run_o), 0);
    step(0, 0, 0, 0, 0, 4'h0, 4'h0, "R3");
    tk("R3");
    chk("R3", "run at tick", int'(run_o), 1);
    chk("R3", "count at start tick", int'(count_o), 0);
    tk("R2");
    chk("R2", "first increment", int'(count_o), 1);
    repeat (4) tk("R2");

    // R4 stop costs one more count
    step(0, 1, 0, 0, 0, 4'h0, 4'h0, "R4");
    chk("R4", "run after stop write", int'(run_o), 1);
    tk("R4");
    chk("R4", "extra count", int'(count_o), 6);
    chk("R4", "run after stop tick", int'(run_o), 0);
    // R5 hold and resume
    repeat (3) tk("R5");
    chk("R5", "held count", int'(count_o), 6);
    step(0, 1, 1, 0, 0, 4'h0, 4'h0, "R5");
    tk("R5");
    tk("R5");
    chk("R5", "resumed count", int'(count_o), 7);

    // R8 set wins over clear on bit 2 fall (7 -> 8)
    step(1, 0, 0, 0, 0, 4'h0, 4'h1, "R8");
    chk("R8", "flag0 set beats clear", int'(flags_o[0]), 1);
    chk("R7", "count 8", int'(count_o), 8);
    // R9 irq from enabled flag
    step(0, 0, 0, 0, 1, 4'h1, 4'h0, "R9");
    chk("R9", "irq enabled", int'(irq_o), 1);
    step(0, 0, 0, 0, 0, 4'h0, 4'h1, "R8");
    chk("R8", "flag0 cleared", int'(flags_o[0]), 0);
    chk("R9", "irq after clear", int'(irq_o), 0);

    // R10 clear wins over a coincident tick while running
    step(1, 1, 1, 1, 0, 4'h0, 4'h0, "R10");
    chk("R10", "clear beats tick", int'(count_o), 0);
    // R7 wrap sets all four flags
    while (count_o != 8'd255) tk("R7");
    step(0, 0, 0, 0, 0, 4'h0, 4'hF, "R8");
    tk("R7");
    chk("R7", "wrap count", int'(count_o), 0);
    chk("R7", "wrap flags", int'(flags_o), 15);

    // R6 clear while stopped is immediate and creates no flags
    step(0, 0, 0, 0, 0, 4'h0, 4'hF, "R8");
    step(0, 1, 0, 0, 0, 4'h0, 4'h0, "R4");
    repeat (40) tk("R5");
    step(0, 1, 0, 1, 0, 4'h0, 4'h0, "R6");
    chk("R6", "stopped clear", int'(count_o), 0);
    chk("R6", "no flags", int'(flags_o), 0);

    // random phase: R2 R3 R4 R6 R7 R8 R9 R10
    for (int i = 0; i < 30000; i++) begin
      logic t, w;
      t = ($urandom_range(0, 2) == 0);
      w = ($urandom_range(0, 39) == 0);
      step(t, w, ($urandom_range(0, 3) != 0), w && ($urandom_range(0, 4) == 0),
           ($urandom_range(0, 63) == 0), 4'($urandom_range(0, 15)),
           (($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'h0),
           "R2 R7 R8 R9 R10");
    end

    finish_run();
  end

endmodule